// File: doc/BRIEF.md
# Dual-Context Page Translation Table

This block caches virtual-to-physical page translations for a word-addressed processor with an 18-bit virtual address space. It keeps two tables, one for executive context and one for user context. Each table has one entry per 512-word page. When paging is disabled, a fixed identity map is used instead. A memory reference gives an address, a current/previous select and a read or write flag. The block answers one cycle later with either a physical address or a fill request to an external page-table walker.

Each entry is a 32-bit word. Bit 31 marks the page modifiable and bit 30 marks it valid. The physical page address sits already shifted into address position. A zero entry is invalid, a positive entry is read-only and a negative entry is read-write, so a sign test and a zero test decide each access. The walker answers a fill by writing an entry back. Software-driven operations can clear one page in both tables or flush both tables completely, for example after a change of a base register.

Top module: `dual_ctx_xlat`

## Requirements
- R1: After reset, rsp_ok and fill_req are 0, and every executive and user entry is invalid, so the first paged read of any page raises a fill.
- R2: An address below 16 bypasses translation. One cycle after the request, rsp_ok=1, rsp_ac=1 and rsp_pa equals the address. No fill is raised, whatever the mode or the table contents.
- R3: With paging_en=0, every read or write hits. rsp_pa equals the 18-bit address, zero-extended, and the table contents do not matter.
- R4: A paged read hits when the selected entry is non-zero. rsp_ok=1 one cycle later, with rsp_pa = entry[19:0] OR addr[8:0]. A zero entry instead sets fill_req, with fill_vpn = addr[17:9], fill_user = the selected table and fill_write=0.
- R5: A paged write hits only when bit 31 of the selected entry is 1. Otherwise it raises a fill with fill_write=1, which covers both invalid and read-only entries.
- R6: The user table is selected when user_mode=1, or when req_prev=1 and user_io=1. Otherwise the executive table is selected.
- R7: fill_req stays 1, with fill_user and fill_vpn unchanged, until a walker write hits the same table and the same page. A write to another table or another page does not clear it. Requests presented while it is set are not accepted: rsp_ok stays 0.
- R8: A page clear (clr_en, clr_vpn) invalidates that page in both the executive and the user table.
- R9: A flush (base_chg) or a reset invalidates every entry in both tables. A walker write in the same cycle as a flush is dropped.
- R10: When a clear and a walker write hit the same page in the same cycle, the page ends invalid. A lookup in the same cycle as a walker write sees the entry as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_en | input | 1 | 1 = translate through the tables, 0 = identity map |
| user_mode | input | 1 | Processor is in user context |
| user_io | input | 1 | Steers previous-context references in executive mode to the user table |
| req_valid | input | 1 | A reference is presented |
| req_addr | input | 18 | Virtual word address |
| req_prev | input | 1 | Reference uses the previous context |
| req_write | input | 1 | 1 = write reference, 0 = read |
| wr_en | input | 1 | Walker writes an entry |
| wr_user | input | 1 | Walker target table (1 = user) |
| wr_vpn | input | 9 | Walker target page |
| wr_data | input | 32 | Entry value written by the walker |
| clr_en | input | 1 | Clear one page in both tables |
| clr_vpn | input | 9 | Page to clear |
| base_chg | input | 1 | Flush both tables |
| rsp_ok | output | 1 | Registered: the reference translated |
| rsp_ac | output | 1 | Registered: the reference went to the register file |
| rsp_pa | output | 20 | Registered physical address |
| fill_req | output | 1 | A fill is pending |
| fill_user | output | 1 | Table of the pending fill |
| fill_vpn | output | 9 | Page of the pending fill |
| fill_write | output | 1 | The pending fill came from a write |

## Verification
The bench builds the block with its defaults: an 18-bit virtual address, 9-bit page offset, 20-bit physical address and 16 registers. With these values the top page 511 and the largest address can be reached in the identity map, and read-only and read-write entries can be set on pages next to each other. The mode vectors cover all combinations of user mode, user-I/O and previous-context select that lead to each table. Directed cases then cover the pending-fill stall, writes to the wrong table or page, same-cycle write/clear and write/lookup collisions, and flush and reset after the tables have been loaded.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned XL_ENTRY_W = 32;
  localparam int unsigned XL_M_BIT   = 31;
  localparam int unsigned XL_V_BIT   = 30;

  typedef logic [XL_ENTRY_W-1:0] xl_entry_t;

  // read needs any non-zero entry; write needs the sign (modifiable) bit
  function automatic logic xl_needs_fill(input xl_entry_t e, input logic is_wr);
    return is_wr ? ~e[XL_M_BIT] : (e == '0);
  endfunction
endpackage

// File: rtl/xlat_ctx_sel.sv
module xlat_ctx_sel (
  input  logic user_mode,
  input  logic user_io,
  input  logic prev,
  output logic sel_user
);
  always_comb sel_user = user_mode | (prev & user_io);
endmodule

// File: rtl/xlat_page_store.sv
module xlat_page_store
  import xlat_pkg::*;
#(
  parameter int unsigned VPN_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  xl_entry_t        wr_data,
  input  logic             clr_en,
  input  logic [VPN_W-1:0] clr_vpn,
  input  logic [VPN_W-1:0] rd_vpn,
  output xl_entry_t        rd_entry
);
  localparam int unsigned ENTRIES = 1 << VPN_W;

  xl_entry_t          mem [ENTRIES];
  logic [ENTRIES-1:0] live;

  // data array: plain write port, no reset, so it maps to RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_vpn] <= wr_data;
  end

  // presence bits: cleared in one cycle on flush or reset
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      live <= '0;
    end else begin
      if (wr_en)  live[wr_vpn]  <= 1'b1;
      if (clr_en) live[clr_vpn] <= 1'b0;
    end
  end

  always_comb rd_entry = live[rd_vpn] ? mem[rd_vpn] : '0;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (live == '0)); // R9

  AST_CLEAR_DROPS_PAGE: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !flush) |=> !live[$past(clr_vpn)]); // R8

  AST_WRITE_FILLS_PAGE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush && !(clr_en && clr_vpn == wr_vpn)) |=> live[$past(wr_vpn)]); // R10
endmodule

// File: rtl/xlat_resolve.sv
module xlat_resolve
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W  = 18,
  parameter int unsigned OFF_W = 9,
  parameter int unsigned PA_W  = 20,
  parameter int unsigned AC_N  = 16
) (
  input  logic            paging_en,
  input  logic            is_wr,
  input  logic [VA_W-1:0] addr,
  input  xl_entry_t       entry,
  output logic            is_ac,
  output logic            hit,
  output logic [PA_W-1:0] pa
);
  localparam int unsigned VPN_W = VA_W - OFF_W;

  xl_entry_t  phys_entry;
  xl_entry_t  eff_entry;
  logic       unused_hi;

  always_comb begin
    phys_entry                  = '0;
    phys_entry[XL_M_BIT]        = 1'b1;
    phys_entry[XL_V_BIT]        = 1'b1;
    phys_entry[OFF_W +: VPN_W]  = addr[VA_W-1:OFF_W];
    eff_entry = paging_en ? entry : phys_entry;
  end

  always_comb begin
    is_ac = (addr < VA_W'(AC_N));
    hit   = is_ac | ~xl_needs_fill(eff_entry, is_wr);
    if (is_ac) pa = PA_W'(addr);
    else       pa = eff_entry[PA_W-1:0] | PA_W'(addr[OFF_W-1:0]);
  end

  assign unused_hi = ^eff_entry[XL_V_BIT:PA_W];
endmodule

// File: rtl/dual_ctx_xlat.sv
module dual_ctx_xlat
  import xlat_pkg::*;
#(
  parameter int unsigned VA_W  = 18,
  parameter int unsigned OFF_W = 9,
  parameter int unsigned PA_W  = 20,
  parameter int unsigned AC_N  = 16,
  localparam int unsigned VPN_W = VA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             paging_en,
  input  logic             user_mode,
  input  logic             user_io,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_addr,
  input  logic             req_prev,
  input  logic             req_write,
  input  logic             wr_en,
  input  logic             wr_user,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [31:0]      wr_data,
  input  logic             clr_en,
  input  logic [VPN_W-1:0] clr_vpn,
  input  logic             base_chg,
  output logic             rsp_ok,
  output logic             rsp_ac,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             fill_req,
  output logic             fill_user,
  output logic [VPN_W-1:0] fill_vpn,
  output logic             fill_write
);
  localparam logic [PA_W-1:0] AC_LIM = PA_W'(AC_N);

  logic             sel_user;
  logic [VPN_W-1:0] rd_vpn;
  xl_entry_t        tbl_entry [2];
  xl_entry_t        sel_entry;
  logic             is_ac, hit, accept, fill_done;
  logic [PA_W-1:0]  pa;

  assign rd_vpn = req_addr[VA_W-1:OFF_W];

  xlat_ctx_sel u_sel (
    .user_mode (user_mode),
    .user_io   (user_io),
    .prev      (req_prev),
    .sel_user  (sel_user)
  );

  // index 0 = executive table, index 1 = user table
  for (genvar t = 0; t < 2; t++) begin : g_tbl
    xlat_page_store #(.VPN_W(VPN_W)) u_store (
      .clk      (clk),
      .rst      (rst),
      .flush    (base_chg),
      .wr_en    (wr_en && (wr_user == 1'(t))),
      .wr_vpn   (wr_vpn),
      .wr_data  (wr_data),
      .clr_en   (clr_en),
      .clr_vpn  (clr_vpn),
      .rd_vpn   (rd_vpn),
      .rd_entry (tbl_entry[t])
    );
  end

  assign sel_entry = tbl_entry[sel_user];

  xlat_resolve #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .AC_N(AC_N)) u_res (
    .paging_en (paging_en),
    .is_wr     (req_write),
    .addr      (req_addr),
    .entry     (sel_entry),
    .is_ac     (is_ac),
    .hit       (hit),
    .pa        (pa)
  );

  assign accept    = req_valid & ~fill_req;
  assign fill_done = wr_en & (wr_user == fill_user) & (wr_vpn == fill_vpn);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ok     <= 1'b0;
      rsp_ac     <= 1'b0;
      rsp_pa     <= '0;
      fill_req   <= 1'b0;
      fill_user  <= 1'b0;
      fill_vpn   <= '0;
      fill_write <= 1'b0;
    end else begin
      rsp_ok <= accept & hit;
      rsp_ac <= accept & is_ac;
      if (accept) rsp_pa <= pa;
      if (accept && !hit) begin
        fill_req   <= 1'b1;
        fill_user  <= sel_user;
        fill_vpn   <= rd_vpn;
        fill_write <= req_write;
      end else if (fill_req && fill_done) begin
        fill_req <= 1'b0;
      end
    end
  end

  AST_AC_BYPASS: assert property (@(posedge clk) disable iff (rst)
    rsp_ac |-> (rsp_ok && rsp_pa < AC_LIM)); // R2

  AST_PHYS_ALWAYS_HITS: assert property (@(posedge clk) disable iff (rst)
    (accept && !paging_en) |=> rsp_ok); // R3

  AST_READ_MISS_ONLY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_write && paging_en && !hit) |-> (sel_entry == '0)); // R4

  AST_WRITE_HIT_MODIFIABLE: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write && paging_en && !is_ac && hit) |-> sel_entry[XL_M_BIT]); // R5

  AST_FILL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !fill_done) |=> (fill_req && $stable(fill_vpn) && $stable(fill_user))); // R7

  AST_FILL_STALLS: assert property (@(posedge clk) disable iff (rst)
    fill_req |=> !rsp_ok); // R7

  AST_FILL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (fill_req && fill_done) |=> !fill_req); // R7
endmodule

// File: tb/dual_ctx_xlat_test.sv
module dual_ctx_xlat_test;
  logic        clk = 1'b0;
  logic        rst, paging_en, user_mode, user_io;
  logic        req_valid, req_prev, req_write;
  logic [17:0] req_addr;
  logic        wr_en, wr_user, clr_en, base_chg;
  logic [8:0]  wr_vpn, clr_vpn;
  logic [31:0] wr_data;
  logic        rsp_ok, rsp_ac, fill_req, fill_user, fill_write;
  logic [19:0] rsp_pa;
  logic [8:0]  fill_vpn;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dual_ctx_xlat uut (
    .clk(clk), .rst(rst), .paging_en(paging_en), .user_mode(user_mode),
    .user_io(user_io), .req_valid(req_valid), .req_addr(req_addr),
    .req_prev(req_prev), .req_write(req_write), .wr_en(wr_en),
    .wr_user(wr_user), .wr_vpn(wr_vpn), .wr_data(wr_data), .clr_en(clr_en),
    .clr_vpn(clr_vpn), .base_chg(base_chg), .rsp_ok(rsp_ok), .rsp_ac(rsp_ac),
    .rsp_pa(rsp_pa), .fill_req(fill_req), .fill_user(fill_user),
    .fill_vpn(fill_vpn), .fill_write(fill_write)
  );

  localparam logic [31:0] E5 = 32'h8002_4600;  // read-write, base 0x24600
  localparam logic [31:0] E6 = 32'h4000_8800;  // read-only,  base 0x08800
  localparam logic [31:0] U5 = 32'h8006_0000;  // read-write, base 0x60000
  localparam logic [31:0] U7 = 32'h4000_2200;  // read-only,  base 0x02200

  // {user_mode, user_io, prev, write, addr[17:0], exp_ok, exp_pa[19:0]}
  localparam int NV = 12;
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 18'h00A1A, 1'b1, 20'h2461A},
    {1'b0, 1'b0, 1'b0, 1'b1, 18'h00A1A, 1'b1, 20'h2461A},
    {1'b0, 1'b0, 1'b0, 1'b0, 18'h00DFF, 1'b1, 20'h089FF},
    {1'b0, 1'b0, 1'b0, 1'b1, 18'h00DFF, 1'b0, 20'h00000},
    {1'b0, 1'b0, 1'b1, 1'b0, 18'h00A1A, 1'b1, 20'h2461A},
    {1'b0, 1'b1, 1'b1, 1'b0, 18'h00A1A, 1'b1, 20'h6001A},
    {1'b0, 1'b1, 1'b0, 1'b0, 18'h00A1A, 1'b1, 20'h2461A},
    {1'b1, 1'b0, 1'b0, 1'b0, 18'h00E03, 1'b1, 20'h02203},
    {1'b1, 1'b0, 1'b1, 1'b1, 18'h00E03, 1'b0, 20'h00000},
    {1'b1, 1'b0, 1'b0, 1'b0, 18'h01000, 1'b0, 20'h00000},
    {1'b0, 1'b0, 1'b0, 1'b0, 18'h0000F, 1'b1, 20'h0000F},
    {1'b1, 1'b0, 1'b0, 1'b1, 18'h00A1A, 1'b1, 20'h6001A}
  };

  function automatic logic [31:0] model_entry(input logic u, input logic [8:0] v);
    if (!u && v == 9'd5) return E5;
    if (!u && v == 9'd6) return E6;
    if ( u && v == 9'd5) return U5;
    if ( u && v == 9'd7) return U7;
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_entry(input logic u, input logic [8:0] v, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_user = u; wr_vpn = v; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic um, input logic uio, input logic pv,
                        input logic w, input logic [17:0] a);
    @(negedge clk);
    user_mode = um; user_io = uio; req_prev = pv; req_write = w;
    req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; paging_en = 1'b1; user_mode = 1'b0; user_io = 1'b0;
    req_valid = 1'b0; req_prev = 1'b0; req_write = 1'b0; req_addr = '0;
    wr_en = 1'b0; wr_user = 1'b0; wr_vpn = '0; wr_data = '0;
    clr_en = 1'b0; clr_vpn = '0; base_chg = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state and empty tables
    chk("R1 rsp_ok after reset", 32'(rsp_ok), 32'h0);
    chk("R1 fill_req after reset", 32'(fill_req), 32'h0);
    lookup(1'b0, 1'b0, 1'b0, 1'b0, 18'h00A1A);
    chk("R1 first read misses", 32'(fill_req), 32'h1);
    chk("R1 fill page", 32'(fill_vpn), 32'd5);
    wr_entry(1'b0, 9'd5, E5);
    chk("R7 fill released by matching write", 32'(fill_req), 32'h0);
    wr_entry(1'b0, 9'd6, E6);
    wr_entry(1'b1, 9'd5, U5);
    wr_entry(1'b1, 9'd7, U7);

    // R2 R4 R5 R6: vector walk
    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      logic        eu;
      v  = VEC[i];
      eu = v[42] | (v[40] & v[41]);
      lookup(v[42], v[41], v[40], v[39], v[38:21]);
      if (v[20]) begin
        chk($sformatf("R4/R5/R6 vec %0d hit", i), 32'(rsp_ok), 32'h1);
        chk($sformatf("R4/R5/R6 vec %0d pa", i), 32'(rsp_pa), 32'(v[19:0]));
        chk($sformatf("R2 vec %0d ac flag", i), 32'(rsp_ac),
            32'(v[38:21] < 18'd16));
      end else begin
        chk($sformatf("R4/R5/R6 vec %0d no hit", i), 32'(rsp_ok), 32'h0);
        chk($sformatf("R4/R5 vec %0d fill", i), 32'(fill_req), 32'h1);
        chk($sformatf("R6 vec %0d fill table", i), 32'(fill_user), 32'(eu));
        chk($sformatf("R4 vec %0d fill page", i), 32'(fill_vpn), 32'(v[38:30]));
        chk($sformatf("R5 vec %0d fill write", i), 32'(fill_write), 32'(v[39]));
        wr_entry(eu, v[38:30], model_entry(eu, v[38:30]));
        chk($sformatf("R7 vec %0d release", i), 32'(fill_req), 32'h0);
      end
    end

    // R7: stall while a fill is pending, wrong writes do not release
    lookup(1'b0, 1'b0, 1'b0, 1'b0, 18'h04000);
    chk("R7 fill raised", 32'(fill_req), 32'h1);
    lookup(1'b0, 1'b0, 1'b0, 1'b0, 18'h00A1A);
    chk("R7 request ignored while pending", 32'(rsp_ok), 32'h0);
    chk("R7 fill page held", 32'(fill_vpn), 32'h20);
    wr_entry(1'b1, 9'h20, 32'h0);
    chk("R7 wrong table keeps fill", 32'(fill_req), 32'h1);
    wr_entry(1'b0, 9'h21, 32'h0);
    chk("R7 wrong page keeps fill", 32'(fill_req), 32'h1);
    wr_entry(1'b0, 9'h20, 32'h0);
    chk("R7 matching write releases", 32'(fill_req), 32'h0);

    // R3: identity map with paging off
    paging_en = 1'b0;
    lookup(1'b1, 1'b0, 1'b0, 1'b1, 18'h3FFFF);
    chk("R3 top address write hits", 32'(rsp_ok), 32'h1);
    chk("R3 top address pa", 32'(rsp_pa), 32'h3FFFF);
    lookup(1'b0, 1'b0, 1'b0, 1'b0, 18'h01000);
    chk("R3 empty page read hits", 32'(rsp_ok), 32'h1);
    chk("R3 empty page pa", 32'(rsp_pa), 32'h01000);
    paging_en = 1'b1;

    // R8: page clear hits both tables
    @(negedge clk); clr_en = 1'b1; clr_vpn = 9'd5;
    @(negedge clk); clr_en = 1'b0;
    lookup(1'b0, 1'b0, 1'b0, 1'b0, 18'h00A1A);
    chk("R8 exec page cleared", 32'(fill_req), 32'h1);
    wr_entry(1'b0, 9'd5, 32'h0);
    lookup(1'b1, 1'b0, 1'b0, 1'b0, 18'h00A1A);
    chk("R8 user page cleared", 32'(fill_req), 32'h1);
    wr_entry(1'b1, 9'd5, 32'h0);

    // R10: clear beats write; lookup sees pre-write entry
    @(negedge clk);
    clr_en = 1'b1; clr_vpn = 9'd9;
    wr_en = 1'b1; wr_user = 1'b0; wr_vpn = 9'd9; wr_data = 32'h8000_1200;
    @(negedge clk); clr_en = 1'b0; wr_en = 1'b0;
    lookup(1'b0, 1'b0, 1'b0, 1'b0, 18'h01200);
    chk("R10 clear wins over write", 32'(fill_req), 32'h1);
    wr_entry(1'b0, 9'd9, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_user = 1'b0; wr_vpn = 9'd10; wr_data = 32'h8000_AA00;
    user_mode = 1'b0; user_io = 1'b0; req_prev = 1'b0; req_write = 1'b0;
    req_addr = 18'h01404; req_valid = 1'b1;
    @(negedge clk); wr_en = 1'b0; req_valid = 1'b0;
    chk("R10 same-cycle lookup sees old entry", 32'(fill_req), 32'h1);
    wr_entry(1'b0, 9'd10, 32'h8000_AA00);
    lookup(1'b0, 1'b0, 1'b0, 1'b0, 18'h01404);
    chk("R10 entry present afterwards", 32'(rsp_pa), 32'h0AA04);

    // R9: flush drops everything, including a same-cycle write
    @(negedge clk);
    base_chg = 1'b1;
    wr_en = 1'b1; wr_user = 1'b1; wr_vpn = 9'd11; wr_data = 32'h8000_1600;
    @(negedge clk); base_chg = 1'b0; wr_en = 1'b0;
    lookup(1'b0, 1'b0, 1'b0, 1'b0, 18'h00DFF);
    chk("R9 flush removed exec entry", 32'(fill_req), 32'h1);
    wr_entry(1'b0, 9'd6, 32'h0);
    lookup(1'b1, 1'b0, 1'b0, 1'b0, 18'h01600);
    chk("R9 same-cycle write dropped", 32'(fill_req), 32'h1);
    wr_entry(1'b1, 9'd11, 32'h0);
    lookup(1'b0, 1'b0, 1'b0, 1'b0, 18'h01404);
    chk("R9 flush removed second entry", 32'(fill_req), 32'h1);
    wr_entry(1'b0, 9'd10, 32'h0);

    // R1: reset after the tables were loaded
    wr_entry(1'b0, 9'd6, E6);
    lookup(1'b0, 1'b0, 1'b0, 1'b0, 18'h00DFF);
    chk("R1 preload before reset", 32'(rsp_pa), 32'h089FF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 rsp_ok cleared by reset", 32'(rsp_ok), 32'h0);
    lookup(1'b0, 1'b0, 1'b0, 1'b0, 18'h00DFF);
    chk("R1 reset emptied table", 32'(fill_req), 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule